// File: doc/BRIEF.md
# Bit-Interleaved TDM Frame Serializer

This block merges four byte-wide sample sources into one serial line. Frames are 33 bit slots long. Slot 0 carries a synchronizing bit. Slots 1 to 32 carry the four bytes, interleaved one bit at a time. Each bit position starts with source 1 and goes from MSB to LSB. At the nominal rate of 10,000 frames per second the line runs at 330 kbit/s. That rate comes from a one-cycle bit-rate enable, pulsed by a divider running off a much faster system clock.

Sample bytes may be written at any time using a load strobe. They go into a holding register. The frame register takes a copy of the holding register at the start of every frame, so a write made during a frame only appears in the next frame. A frame-start output is high for the whole bit period of each synchronizing bit. The synchronizing bit alternates from frame to frame, which lets a receiver find frame boundaries.

A controller state machine has three named states:
- `ST_IDLE`: after reset, no frame yet.
- `ST_SYNC`: the synchronizing bit is on the line.
- `ST_DATA`: data bits are on the line.

It has four named transitions:
- `IDLE→SYNC`: on the first enable.
- `SYNC→DATA`: on the next enable.
- `DATA→DATA`: on an enable while data bits remain.
- `DATA→SYNC`: on the enable after slot 32.

There are no gap slots between frames.

Top module: `tdm_frame_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first bit-rate enable, `ser_out` and `frame_start` are both 0.
- R2: Every frame occupies exactly 33 successive enabled bit periods. Slot 0 is the synchronizing bit and slots 1 to 32 are data. The next frame's slot 0 follows slot 32 directly.
- R3: Data slot 1+4*(7-b)+s carries bit b of source s. Source s is `sample_bus[8*s+7 : 8*s]`, with s=0 being the first source. The line order is therefore s0[7], s1[7], s2[7], s3[7], s0[6], and so on down to s3[0].
- R4: The synchronizing bit is 1 in the first frame after reset and inverts in each following frame.
- R5: `frame_start` is 1 for exactly the bit period of slot 0, and 0 during data slots.
- R6: `ser_out` and `frame_start` change only on clock edges where `bit_en` is 1.
- R7: Bytes are captured into the frame only when slot 0 starts. A load made during a frame leaves that frame unchanged and appears in the following frame.
- R8: A load in the same clock cycle as the enable that starts slot 0 is included in that frame.
- R9: If no load happens between frames, the next frame repeats the most recently loaded bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-rate enable; advances one bit slot |
| sample_load | input | 1 | Writes `sample_bus` into the holding register |
| sample_bus | input | 32 | Four sample bytes; source s in bits [8s+7:8s] |
| ser_out | output | 1 | Serial line |
| frame_start | output | 1 | High during the synchronizing bit period |

## Verification
The hardest cases to reach are the two capture boundaries. One is a load during a frame, which must stay out of the current frame and yet appear in the next. The other is a load in the exact cycle of the slot-0 enable, which must enter the current frame. The bench generates `bit_en` itself, so it can place the load strobe on the slot-0 enable cycle or partway through the data slots. It then sends a frame with no load at all, which exposes whichever bytes the holding register kept.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int unsigned TDM_SOURCES = 4;
    localparam int unsigned TDM_SAMPLE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } tdm_state_e;

endpackage

// File: rtl/tdm_sample_latch.sv
module tdm_sample_latch #(
    parameter int unsigned NSRC = 4,
    parameter int unsigned SW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NSRC*SW-1:0]   load_bus,
    input  logic                 capture,
    output logic [NSRC*SW-1:0]   frame_bus
);
    logic [NSRC*SW-1:0] hold_q;
    logic [NSRC*SW-1:0] frame_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[s*SW +: SW]  <= '0;
                frame_q[s*SW +: SW] <= '0;
            end else begin
                if (load)
                    hold_q[s*SW +: SW] <= load_bus[s*SW +: SW];
                if (capture)
                    frame_q[s*SW +: SW] <= load ? load_bus[s*SW +: SW]
                                                : hold_q[s*SW +: SW];
            end
        end
    end

    assign frame_bus = frame_q;

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(frame_q)); // R7

    AST_SAME_CYCLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && load) |=> frame_q == $past(load_bus)); // R8

endmodule

// File: rtl/tdm_bit_select.sv
module tdm_bit_select #(
    parameter int unsigned NSRC = 4,
    parameter int unsigned SW   = 8,
    parameter int unsigned IDXW = 6
) (
    input  logic [NSRC*SW-1:0] frame_bus,
    input  logic [IDXW-1:0]    idx,
    output logic               data_bit
);
    localparam int unsigned NDATA = NSRC * SW;

    logic [NDATA-1:0] line_order;

    for (genvar k = 0; k < NDATA; k++) begin : g_order
        assign line_order[k] = frame_bus[(k % NSRC) * SW + (SW - 1 - k / NSRC)];
    end

    always_comb begin
        data_bit = 1'b0;
        if (32'(idx) < NDATA)
            data_bit = line_order[idx];
    end

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_pkg::*;
#(
    parameter int unsigned NDATA = 32,
    parameter int unsigned IDXW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            data_bit,
    output logic            capture,
    output logic [IDXW-1:0] data_idx,
    output logic            ser_out,
    output logic            frame_start
);
    tdm_state_e      state_q, state_n;
    logic [IDXW-1:0] cnt_q;
    logic            sync_ph_q;
    logic            last_slot;

    assign last_slot = (32'(cnt_q) == NDATA);
    assign data_idx  = cnt_q;

    always_comb begin
        state_n = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: if (bit_en) begin
                state_n = ST_SYNC;
                capture = 1'b1;
            end
            ST_SYNC: if (bit_en) state_n = ST_DATA;
            ST_DATA: if (bit_en && last_slot) begin
                state_n = ST_SYNC;
                capture = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out     <= 1'b0;
            frame_start <= 1'b0;
            sync_ph_q   <= 1'b1;
            cnt_q       <= '0;
        end else if (bit_en) begin
            if (capture) begin
                ser_out     <= sync_ph_q;
                frame_start <= 1'b1;
                sync_ph_q   <= ~sync_ph_q;
                cnt_q       <= '0;
            end else if (state_q != ST_IDLE) begin
                ser_out     <= data_bit;
                frame_start <= 1'b0;
                cnt_q       <= cnt_q + 1'b1;
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= NDATA); // R2

    AST_SYNC_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> sync_ph_q != $past(sync_ph_q)); // R4

    AST_FS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> frame_start); // R5

    AST_FS_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && bit_en) |=> !frame_start); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(frame_start))); // R6

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
    import tdm_pkg::*;
#(
    parameter int unsigned NSRC = TDM_SOURCES,
    parameter int unsigned SW   = TDM_SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 sample_load,
    input  logic [NSRC*SW-1:0]   sample_bus,
    output logic                 ser_out,
    output logic                 frame_start
);
    localparam int unsigned NDATA = NSRC * SW;
    localparam int unsigned IDXW  = $clog2(NDATA + 1);

    logic              capture;
    logic [NDATA-1:0]  frame_bus;
    logic [IDXW-1:0]   data_idx;
    logic              data_bit;

    tdm_sample_latch #(.NSRC(NSRC), .SW(SW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sample_load),
        .load_bus  (sample_bus),
        .capture   (capture),
        .frame_bus (frame_bus)
    );

    tdm_bit_select #(.NSRC(NSRC), .SW(SW), .IDXW(IDXW)) u_select (
        .frame_bus (frame_bus),
        .idx       (data_idx),
        .data_bit  (data_bit)
    );

    tdm_frame_ctrl #(.NDATA(NDATA), .IDXW(IDXW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .data_bit    (data_bit),
        .capture     (capture),
        .data_idx    (data_idx),
        .ser_out     (ser_out),
        .frame_start (frame_start)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && !frame_start)); // R1

endmodule

// File: tb/tb_tdm_frame_serializer.sv
module tb_tdm_frame_serializer;

    typedef struct {
        logic fs;
        logic b;
        int   req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        sample_load = 1'b0;
    logic [31:0] sample_bus = '0;
    logic        ser_out;
    logic        frame_start;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    logic [31:0] hold_m = '0;
    logic [31:0] frame_m = '0;
    logic        sync_m = 1'b1;
    logic        last_ser = 1'b0;
    logic        last_fs = 1'b0;

    always #10 clk = ~clk;

    tdm_frame_serializer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .sample_load (sample_load),
        .sample_bus  (sample_bus),
        .ser_out     (ser_out),
        .frame_start (frame_start)
    );

    task automatic check(input int req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Monitor: on enabled edges pop an expected slot; otherwise outputs must hold (R6).
    always @(posedge clk) begin
        if (rst_n) begin
            if (bit_en) begin
                #2;
                if (expq.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R2 unexpected slot: actual %b expected none", ser_out);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(e.req, ser_out, e.b, "ser_out");
                    check(5, frame_start, e.fs, "frame_start"); // R5
                end
            end else begin
                #2;
                check(6, ser_out, last_ser, "ser_out hold");         // R6
                check(6, frame_start, last_fs, "frame_start hold");  // R6
            end
            last_ser = ser_out;
            last_fs  = frame_start;
        end
    end

    // Driver: one full frame of 33 enabled slots, pushing expected slots.
    task automatic send_frame(input logic [31:0] bytes, input bit preload, input bit coincide,
                              input bit midload, input logic [31:0] mid_bytes, input int req);
        if (preload && !coincide) begin
            @(negedge clk);
            sample_load = 1'b1; sample_bus = bytes; hold_m = bytes;
            @(negedge clk);
            sample_load = 1'b0;
        end
        for (int slot = 0; slot < 33; slot++) begin
            exp_t e;
            @(negedge clk);
            bit_en = 1'b1;
            if (slot == 0) begin
                if (coincide) begin
                    sample_load = 1'b1; sample_bus = bytes; hold_m = bytes;
                end
                frame_m = hold_m;
                e.fs = 1'b1; e.b = sync_m; e.req = 4; // R4 sync value
                sync_m = ~sync_m;
            end else begin
                int k = slot - 1;
                e.fs = 1'b0;
                e.b = frame_m[(k % 4) * 8 + 7 - k / 4]; // R3 order
                e.req = req;
            end
            if (midload && slot == 12) begin
                sample_load = 1'b1; sample_bus = mid_bytes; hold_m = mid_bytes;
            end
            expq.push_back(e);
            @(negedge clk);
            bit_en = 1'b0; sample_load = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(1, ser_out, 1'b0, "reset ser_out");      // R1
        check(1, frame_start, 1'b0, "reset frame_start"); // R1
        rst_n = 1'b1;
        // R1: idle with no enable, nothing leaves the block
        repeat (10) @(negedge clk);
        check(1, ser_out, 1'b0, "idle ser_out");
        check(1, frame_start, 1'b0, "idle frame_start");

        send_frame(32'h0F_F0_3C_A5, 1, 0, 0, '0, 3);            // R3 first frame
        send_frame(32'h81_42_24_18, 1, 0, 1, 32'h5A_C3_96_E7, 7); // R7 mid-frame load kept out
        send_frame('0, 0, 0, 0, '0, 7);                          // R7 mid load shows next frame
        send_frame(32'hDE_AD_BE_EF, 1, 1, 0, '0, 8);             // R8 load on slot-0 enable
        send_frame('0, 0, 0, 0, '0, 9);                          // R9 repeat with no load
        send_frame(32'hFF_00_FF_00, 1, 0, 0, '0, 2);             // R2 back-to-back frames

        repeat (8) @(negedge clk);
        n_checks++;
        if (expq.size() != 0) begin
            n_fail++;
            $display("FAIL R2 leftover slots: actual %0d expected 0", expq.size());
        end
        finish_run();
    end

endmodule